// File: doc/BRIEF.md
# Two-Channel Power-of-Two Prescaled Interval Timer

This block is a memory-mapped interval timer with two independent channels that run from one common clock. Each channel has a reload value, an up-counter that software can read while it runs, and its own power-of-two clock divider. A channel runs in one of two modes. In periodic mode the counter wraps after every period. In single-shot mode the channel stops itself after the first period. Each expiry latches a status flag. The status flag, gated by a per-channel interrupt enable, drives a level interrupt line.

Software reaches the channels over a simple 16-bit register bus. A write completes on the clock edge where `bus_en` and `bus_we` are both high. A read request is taken on the edge where `bus_en` is high and `bus_we` is low, and its data is valid on `bus_rdata` after that edge. Software stops a channel by clearing its enable bit. It may then change the reload value and set the enable bit again to start a fresh period. Because the divider and the counter restart together, the first period of every run has its full length.

Top module: `gpt_dual_timer`

## Requirements
- R1: After reset, every register of both channels reads 0 and both `irq` bits are low.
- R2: Channel n (n = 0, 1) has four registers at byte address 0x80 + n*0x80 plus an offset: control at +0x0, status at +0x4, reload at +0x8 and counter at +0xC. Read data appears one cycle after the request. In control, bit 8 is the interrupt enable, bit 5 is the run enable, bit 4 selects single-shot mode (0 selects periodic) and bits 3:0 hold the divider code. All other control bits read 0. The reload register reads back its 16-bit value.
- R3: When the run enable goes from 0 to 1, the counter and the divider both restart from 0. The counter then rises by one every 2^k clock cycles, where k is the divider code. The counter register ignores writes.
- R4: In periodic mode, a divided tick that arrives while the counter equals the reload value L sets the status flag and returns the counter to 0. The period is (L+1)*2^k cycles.
- R5: In single-shot mode, the expiring tick sets the status flag and clears the run enable bit. The counter then holds at L.
- R6: Each `irq` bit is a register. It equals the channel's status flag ANDed with its interrupt enable, and it changes on the same edge as either of them.
- R7: Writing 1 to bit 0 of the status register clears the flag. Writing 0 there leaves the flag unchanged.
- R8: Divider codes 9 to 15 divide by 256.
- R9: An address outside the eight mapped registers reads 0, and writes to it change no register.
- R10: Clearing the run enable freezes the counter at its value from the previous cycle, and a tick in that cycle has no effect. The two channels do not affect each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared functional clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_en | input | 1 | Register access request |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W (9) | Byte address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data |
| irq | output | NUM_CH (2) | Per-channel level interrupt |

## Verification
The bench builds the timer with its default parameters: two channels, 16-bit counters, a 9-bit address and a largest divide of 256. Small reload values with codes 0, 1 and 2 bring several wraps, a single-shot stop and a stop/restart within a few hundred cycles. A clamped code of 12 with a reload of 1 reaches the /256 expiry in 512 cycles. The bench predicts counter values from the number of edges since the enabling write, so an off-by-one in the divider restart or the wrap point shows up directly.

// File: rtl/gpt_pkg.sv
package gpt_pkg;
  localparam int unsigned DATA_W     = 16;
  localparam int unsigned CODE_W     = 4;
  localparam int unsigned CTL_IE_BIT = 8;
  localparam int unsigned CTL_EN_BIT = 5;
  localparam int unsigned CTL_OS_BIT = 4;
  localparam int unsigned STS_BIT    = 0;
  localparam int unsigned CH_BASE    = 128;
  localparam int unsigned CH_STRIDE  = 128;
  localparam int unsigned OFF_CTRL   = 0;
  localparam int unsigned OFF_STS    = 4;
  localparam int unsigned OFF_LOAD   = 8;
  localparam int unsigned OFF_CNT    = 12;

  typedef struct packed {
    logic              ie;
    logic              en;
    logic              oneshot;
    logic [CODE_W-1:0] code;
  } ctl_t;
endpackage

// File: rtl/gpt_prescaler.sv
module gpt_prescaler
  import gpt_pkg::*;
#(
  parameter int unsigned LOG_MAX = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              restart,
  input  logic              run,
  input  logic [CODE_W-1:0] code,
  output logic              tick
);
  localparam int unsigned PW = (LOG_MAX < 1) ? 1 : LOG_MAX;

  logic [CODE_W-1:0] eff;
  logic [PW:0]       span;
  logic [PW-1:0]     mask;
  logic [PW-1:0]     cnt_q;

  assign eff  = (code > CODE_W'(LOG_MAX)) ? CODE_W'(LOG_MAX) : code;
  assign span = (PW+1)'(1) << eff;
  assign mask = PW'(span - (PW+1)'(1));
  assign tick = run && (cnt_q >= mask);

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      cnt_q <= '0;
    end else if (run) begin
      cnt_q <= tick ? '0 : cnt_q + PW'(1);
    end
  end
endmodule

// File: rtl/gpt_channel.sv
module gpt_channel
  import gpt_pkg::*;
#(
  parameter int unsigned CNT_W   = 16,
  parameter int unsigned LOG_MAX = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_ctrl,
  input  logic              wr_sts,
  input  logic              wr_load,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] ctrl_o,
  output logic [DATA_W-1:0] sts_o,
  output logic [DATA_W-1:0] load_o,
  output logic [DATA_W-1:0] cnt_o,
  output logic              irq_o
);
  ctl_t             ctl_q, ctl_n, ctl_wr;
  logic             sts_q, sts_n;
  logic [CNT_W-1:0] load_q, load_n;
  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic             irq_q;
  logic             start, stop_wr, tick, live_tick, expire;

  assign ctl_wr.ie      = wdata[CTL_IE_BIT];
  assign ctl_wr.en      = wdata[CTL_EN_BIT];
  assign ctl_wr.oneshot = wdata[CTL_OS_BIT];
  assign ctl_wr.code    = wdata[CODE_W-1:0];

  assign start     = wr_ctrl && ctl_wr.en && !ctl_q.en;
  assign stop_wr   = wr_ctrl && !ctl_wr.en;
  assign live_tick = tick && !stop_wr;
  assign expire    = live_tick && (cnt_q == load_q);

  gpt_prescaler #(.LOG_MAX(LOG_MAX)) u_psc (
    .clk    (clk),
    .rst    (rst),
    .restart(start),
    .run    (ctl_q.en),
    .code   (ctl_q.code),
    .tick   (tick)
  );

  always_comb begin
    ctl_n = ctl_q;
    if (wr_ctrl) begin
      ctl_n = ctl_wr;
    end else if (expire && ctl_q.oneshot) begin
      ctl_n.en = 1'b0;
    end

    cnt_n = cnt_q;
    if (start) begin
      cnt_n = '0;
    end else if (live_tick) begin
      if (expire) begin
        cnt_n = ctl_q.oneshot ? cnt_q : '0;
      end else begin
        cnt_n = cnt_q + CNT_W'(1);
      end
    end

    sts_n = sts_q;
    if (expire) begin
      sts_n = 1'b1;
    end else if (wr_sts && wdata[STS_BIT]) begin
      sts_n = 1'b0;
    end

    load_n = wr_load ? wdata[CNT_W-1:0] : load_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q  <= '0;
      cnt_q  <= '0;
      sts_q  <= 1'b0;
      load_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      ctl_q  <= ctl_n;
      cnt_q  <= cnt_n;
      sts_q  <= sts_n;
      load_q <= load_n;
      irq_q  <= sts_n && ctl_n.ie;
    end
  end

  always_comb begin
    ctrl_o                      = '0;
    ctrl_o[CTL_IE_BIT]          = ctl_q.ie;
    ctrl_o[CTL_EN_BIT]          = ctl_q.en;
    ctrl_o[CTL_OS_BIT]          = ctl_q.oneshot;
    ctrl_o[CODE_W-1:0]          = ctl_q.code;
    sts_o                       = '0;
    sts_o[STS_BIT]              = sts_q;
  end

  assign load_o = DATA_W'(load_q);
  assign cnt_o  = DATA_W'(cnt_q);
  assign irq_o  = irq_q;
endmodule

// File: rtl/gpt_regbus.sv
module gpt_regbus
  import gpt_pkg::*;
#(
  parameter int unsigned NUM_CH = 2,
  parameter int unsigned ADDR_W = 9
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           bus_en,
  input  logic                           bus_we,
  input  logic [ADDR_W-1:0]              bus_addr,
  input  logic [NUM_CH-1:0][DATA_W-1:0]  ctrl_i,
  input  logic [NUM_CH-1:0][DATA_W-1:0]  sts_i,
  input  logic [NUM_CH-1:0][DATA_W-1:0]  load_i,
  input  logic [NUM_CH-1:0][DATA_W-1:0]  cnt_i,
  output logic [NUM_CH-1:0]              wr_ctrl_o,
  output logic [NUM_CH-1:0]              wr_sts_o,
  output logic [NUM_CH-1:0]              wr_load_o,
  output logic [DATA_W-1:0]              rdata_o
);
  localparam int unsigned WIN_LSB = $clog2(CH_STRIDE);
  localparam int unsigned SEL_W   = ADDR_W - WIN_LSB;
  localparam int unsigned FIRST   = CH_BASE / CH_STRIDE;

  logic [WIN_LSB-1:0] off;
  logic [SEL_W-1:0]   win;
  logic               is_ctrl, is_sts, is_load, is_cnt, wr_req;
  logic [NUM_CH-1:0]  hit;
  logic [DATA_W-1:0]  rd_n;

  assign off     = bus_addr[WIN_LSB-1:0];
  assign win     = bus_addr[ADDR_W-1:WIN_LSB];
  assign is_ctrl = (off == WIN_LSB'(OFF_CTRL));
  assign is_sts  = (off == WIN_LSB'(OFF_STS));
  assign is_load = (off == WIN_LSB'(OFF_LOAD));
  assign is_cnt  = (off == WIN_LSB'(OFF_CNT));
  assign wr_req  = bus_en && bus_we;

  for (genvar i = 0; i < NUM_CH; i++) begin : g_dec
    assign hit[i]       = (win == SEL_W'(i + FIRST));
    assign wr_ctrl_o[i] = wr_req && hit[i] && is_ctrl;
    assign wr_sts_o[i]  = wr_req && hit[i] && is_sts;
    assign wr_load_o[i] = wr_req && hit[i] && is_load;
  end

  always_comb begin
    rd_n = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (hit[i]) begin
        if (is_ctrl) rd_n = ctrl_i[i];
        if (is_sts)  rd_n = sts_i[i];
        if (is_load) rd_n = load_i[i];
        if (is_cnt)  rd_n = cnt_i[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_o <= '0;
    end else begin
      rdata_o <= (bus_en && !bus_we) ? rd_n : '0;
    end
  end
endmodule

// File: rtl/gpt_dual_timer.sv
module gpt_dual_timer
  import gpt_pkg::*;
#(
  parameter int unsigned NUM_CH  = 2,
  parameter int unsigned ADDR_W  = 9,
  parameter int unsigned CNT_W   = 16,
  parameter int unsigned LOG_MAX = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [15:0]       bus_wdata,
  output logic [15:0]       bus_rdata,
  output logic [NUM_CH-1:0] irq
);
  logic [NUM_CH-1:0][DATA_W-1:0] ch_ctrl, ch_sts, ch_load, ch_cnt;
  logic [NUM_CH-1:0]             wr_ctrl, wr_sts, wr_load;
  logic [NUM_CH-1:0]             ch_ie, ch_en, ch_os, ch_flag;
  logic [NUM_CH-1:0][CNT_W-1:0]  ch_val;

  gpt_regbus #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_bus (
    .clk      (clk),
    .rst      (rst),
    .bus_en   (bus_en),
    .bus_we   (bus_we),
    .bus_addr (bus_addr),
    .ctrl_i   (ch_ctrl),
    .sts_i    (ch_sts),
    .load_i   (ch_load),
    .cnt_i    (ch_cnt),
    .wr_ctrl_o(wr_ctrl),
    .wr_sts_o (wr_sts),
    .wr_load_o(wr_load),
    .rdata_o  (bus_rdata)
  );

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    gpt_channel #(.CNT_W(CNT_W), .LOG_MAX(LOG_MAX)) u_ch (
      .clk    (clk),
      .rst    (rst),
      .wr_ctrl(wr_ctrl[i]),
      .wr_sts (wr_sts[i]),
      .wr_load(wr_load[i]),
      .wdata  (bus_wdata),
      .ctrl_o (ch_ctrl[i]),
      .sts_o  (ch_sts[i]),
      .load_o (ch_load[i]),
      .cnt_o  (ch_cnt[i]),
      .irq_o  (irq[i])
    );
    assign ch_ie[i]   = ch_ctrl[i][CTL_IE_BIT];
    assign ch_en[i]   = ch_ctrl[i][CTL_EN_BIT];
    assign ch_os[i]   = ch_ctrl[i][CTL_OS_BIT];
    assign ch_flag[i] = ch_sts[i][STS_BIT];
    assign ch_val[i]  = ch_cnt[i][CNT_W-1:0];
  end
endmodule

// File: rtl/gpt_dual_timer_chk.sv
module gpt_dual_timer_chk #(
  parameter int unsigned NUM_CH = 2,
  parameter int unsigned ADDR_W = 9,
  parameter int unsigned CNT_W  = 16
) (
  input logic                           clk,
  input logic                           rst,
  input logic                           bus_en,
  input logic                           bus_we,
  input logic [ADDR_W-1:0]              bus_addr,
  input logic                           wd0,
  input logic [15:0]                    bus_rdata,
  input logic [NUM_CH-1:0]              irq,
  input logic [NUM_CH-1:0]              ch_ie,
  input logic [NUM_CH-1:0]              ch_en,
  input logic [NUM_CH-1:0]              ch_os,
  input logic [NUM_CH-1:0]              ch_flag,
  input logic [NUM_CH-1:0][CNT_W-1:0]   ch_val
);
  int unsigned win_idx;
  logic        mapped;
  assign win_idx = int'(bus_addr) / 128;
  assign mapped  = (win_idx >= 1) && (win_idx <= NUM_CH) &&
                   (bus_addr[1:0] == 2'b00) && ((int'(bus_addr) % 128) < 16);

  p_unmapped_rd_r9: assert property (@(posedge clk) disable iff (rst)
    (bus_en && !bus_we && !mapped) |=> (bus_rdata == 16'h0000));

  for (genvar i = 0; i < NUM_CH; i++) begin : g_a
    localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(128 + i*128);
    localparam logic [ADDR_W-1:0] A_STS  = ADDR_W'(128 + i*128 + 4);

    p_irq_gate_r6: assert property (@(posedge clk) disable iff (rst)
      irq[i] |-> (ch_flag[i] && ch_ie[i]));

    p_cnt_step_r3: assert property (@(posedge clk) disable iff (rst)
      ($past(ch_en[i]) && ch_en[i] && (ch_val[i] != '0)) |->
        ((ch_val[i] == $past(ch_val[i])) || (ch_val[i] == CNT_W'($past(ch_val[i]) + 1))));

    p_stopped_hold_r10: assert property (@(posedge clk) disable iff (rst)
      (!$past(ch_en[i]) && !ch_en[i]) |-> (ch_val[i] == $past(ch_val[i])));

    p_oneshot_stop_r5: assert property (@(posedge clk) disable iff (rst)
      ($fell(ch_en[i]) && !$past(bus_en && bus_we && (bus_addr == A_CTRL))) |->
        (ch_flag[i] && ch_os[i]));

    p_sts_clear_r7: assert property (@(posedge clk) disable iff (rst)
      ($past(ch_flag[i]) && !ch_flag[i]) |->
        $past(bus_en && bus_we && (bus_addr == A_STS) && wd0));
  end
endmodule

bind gpt_dual_timer gpt_dual_timer_chk #(
  .NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .CNT_W(CNT_W)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .bus_en   (bus_en),
  .bus_we   (bus_we),
  .bus_addr (bus_addr),
  .wd0      (bus_wdata[0]),
  .bus_rdata(bus_rdata),
  .irq      (irq),
  .ch_ie    (ch_ie),
  .ch_en    (ch_en),
  .ch_os    (ch_os),
  .ch_flag  (ch_flag),
  .ch_val   (ch_val)
);

// File: tb/sim_gpt_dual_timer.sv
`timescale 1ns/1ps
module sim_gpt_dual_timer;
  localparam int AW = 9;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          bus_en = 1'b0;
  logic          bus_we = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [15:0]   bus_wdata = '0;
  wire  [15:0]   bus_rdata;
  wire  [1:0]    irq;

  gpt_dual_timer u0 (
    .clk(clk), .rst(rst), .bus_en(bus_en), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  always #4 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  typedef struct {
    logic [15:0] exp;
    string       tag;
  } item_t;
  item_t sb_q[$];

  logic rd_seen = 1'b0;
  always @(posedge clk) rd_seen <= bus_en && !bus_we;

  always @(negedge clk) begin
    if (rd_seen) begin
      if (sb_q.size() == 0) begin
        n_chk++; n_fail++;
        $display("FAIL scoreboard empty act=%h exp=none", bus_rdata);
      end else begin
        item_t it;
        it = sb_q.pop_front();
        n_chk++;
        if (bus_rdata !== it.exp) begin
          n_fail++;
          $display("FAIL %s act=%h exp=%h", it.tag, bus_rdata, it.exp);
        end
      end
    end
  end

  task automatic check(input logic [15:0] act, input logic [15:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [15:0] d, output int e);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b1; bus_addr = AW'(a); bus_wdata = d;
    e = cyc + 1;
  endtask

  task automatic rd(input int a, input logic [15:0] exp, input string tag);
    item_t it;
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b0; bus_addr = AW'(a);
    it.exp = exp; it.tag = tag;
    sb_q.push_back(it);
  endtask

  // expected counter value after the edge numbered "c" for a run started at edge e
  function automatic logic [15:0] model(input int c, input int e, input int d,
                                        input int l, input bit os);
    int t;
    t = (c - e) / d;
    if (os) return 16'((t > l) ? l : t);
    return 16'(t % (l + 1));
  endfunction

  task automatic rd_cnt(input int a, input int e, input int d, input int l,
                        input bit os, input string tag);
    item_t it;
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b0; bus_addr = AW'(a);
    it.exp = model(cyc, e, d, l, os); it.tag = tag;
    sb_q.push_back(it);
  endtask

  task automatic idle_to(input int c);
    do begin
      @(negedge clk);
      bus_en = 1'b0; bus_we = 1'b0;
    end while (cyc < c);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog act=timeout exp=finish");
    finish_run();
  end

  initial begin
    int e, e2, es, stop_val;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;

    // R1 reset state
    check({14'd0, irq}, 16'h0000, "R1 irq after reset");
    rd(16'h080, 16'h0000, "R1 ch0 ctrl"); rd(16'h084, 16'h0000, "R1 ch0 sts");
    rd(16'h088, 16'h0000, "R1 ch0 load"); rd(16'h08C, 16'h0000, "R1 ch0 cnt");
    rd(16'h100, 16'h0000, "R1 ch1 ctrl"); rd(16'h104, 16'h0000, "R1 ch1 sts");
    rd(16'h108, 16'h0000, "R1 ch1 load"); rd(16'h10C, 16'h0000, "R1 ch1 cnt");

    // R2 register map and field readback
    wr(16'h088, 16'h1234, e); wr(16'h108, 16'hBEEF, e);
    wr(16'h080, 16'hFFD3, e);
    rd(16'h088, 16'h1234, "R2 ch0 load readback");
    rd(16'h108, 16'hBEEF, "R2 ch1 load readback");
    rd(16'h080, 16'h0113, "R2 ch0 ctrl fields");
    rd(16'h100, 16'h0000, "R10 ch1 ctrl untouched");
    // R3 counter ignores writes
    wr(16'h08C, 16'h5555, e);
    rd(16'h08C, 16'h0000, "R3 count write ignored");
    wr(16'h080, 16'h0000, e);
    idle_to(cyc + 2);
    check({14'd0, irq}, 16'h0000, "R6 no irq without status");

    // R4 periodic: load 4, code 1 (/2), irq enabled
    wr(16'h088, 16'd4, e);
    wr(16'h080, 16'h0121, e);
    idle_to(e + 9);
    check({15'd0, irq[0]}, 16'h0000, "R4 irq before first expiry");
    idle_to(e + 10);
    check({15'd0, irq[0]}, 16'h0001, "R4 R6 irq at first expiry");
    for (int k = 0; k < 12; k++) rd_cnt(16'h08C, e, 2, 4, 1'b0, "R3 R4 periodic count");
    rd(16'h084, 16'h0001, "R4 status set");

    // R10 stop freezes the counter
    wr(16'h080, 16'h0100, es);
    stop_val = int'(model(es - 1, e, 2, 4, 1'b0));
    idle_to(es + 7);
    rd(16'h08C, 16'(stop_val), "R10 count frozen");
    rd(16'h080, 16'h0100, "R10 enable cleared");
    // R7 status clear
    wr(16'h084, 16'h0000, e2);
    rd(16'h084, 16'h0001, "R7 write 0 keeps status");
    idle_to(cyc + 1);
    check({15'd0, irq[0]}, 16'h0001, "R7 irq kept");
    wr(16'h084, 16'h0001, e2);
    rd(16'h084, 16'h0000, "R7 write 1 clears status");
    idle_to(cyc + 1);
    check({15'd0, irq[0]}, 16'h0000, "R6 R7 irq drops");

    // R5 single-shot on ch1: load 3, code 0, irq disabled
    wr(16'h108, 16'd3, e);
    wr(16'h100, 16'h0030, e);
    idle_to(e + 8);
    rd(16'h100, 16'h0010, "R5 enable self-cleared");
    rd(16'h10C, 16'h0003, "R5 count holds at load");
    rd(16'h104, 16'h0001, "R5 status set");
    idle_to(cyc + 1);
    check({15'd0, irq[1]}, 16'h0000, "R6 irq gated by enable bit");
    rd(16'h08C, 16'(stop_val), "R10 ch0 unaffected by ch1");
    wr(16'h100, 16'h0110, e);
    idle_to(e);
    check({15'd0, irq[1]}, 16'h0001, "R6 irq follows enable bit");

    // R8 clamped code 12 acts as /256, load 1
    wr(16'h104, 16'h0001, e);
    wr(16'h108, 16'd1, e);
    wr(16'h100, 16'h013C, e);
    idle_to(e + 511);
    check({15'd0, irq[1]}, 16'h0000, "R8 no expiry before 512 cycles");
    idle_to(e + 512);
    check({15'd0, irq[1]}, 16'h0001, "R8 expiry at 512 cycles");
    rd(16'h100, 16'h011C, "R8 R5 ctrl after expiry");
    rd(16'h10C, 16'h0001, "R8 count holds");

    // R3 restart of divider and counter: ch0 load 50, code 2 (/4)
    wr(16'h088, 16'd50, e);
    wr(16'h080, 16'h0022, e);
    idle_to(e + 5);
    for (int k = 0; k < 6; k++) rd_cnt(16'h08C, e, 4, 50, 1'b0, "R3 divided count");
    wr(16'h080, 16'h0002, es);
    idle_to(es + 5);
    wr(16'h080, 16'h0022, e);
    for (int k = 0; k < 10; k++) rd_cnt(16'h08C, e, 4, 50, 1'b0, "R3 restart from zero");
    idle_to(cyc + 1);
    check({15'd0, irq[0]}, 16'h0000, "R6 ch0 irq disabled");

    // R9 unmapped addresses
    wr(16'h090, 16'hFFFF, e); wr(16'h000, 16'hFFFF, e);
    wr(16'h08A, 16'hFFFF, e); wr(16'h180, 16'hFFFF, e);
    rd(16'h090, 16'h0000, "R9 read 0x090");
    rd(16'h000, 16'h0000, "R9 read 0x000");
    rd(16'h08A, 16'h0000, "R9 read 0x08A");
    rd(16'h180, 16'h0000, "R9 read 0x180");
    rd(16'h088, 16'd50,   "R9 ch0 load intact");
    rd(16'h080, 16'h0022, "R9 ch0 ctrl intact");
    rd(16'h100, 16'h011C, "R9 ch1 ctrl intact");
    rd(16'h108, 16'h0001, "R9 ch1 load intact");

    idle_to(cyc + 4);
    if (sb_q.size() != 0) begin
      n_chk++; n_fail++;
      $display("FAIL scoreboard leftover act=%0d exp=0", sb_q.size());
    end
    finish_run();
  end
endmodule